// File: doc/BRIEF.md
# Frame Sync Phase Adjustment Generator

This block paces the serial data port of an audio codec. Running on the master clock, it marks the start of every sample frame with a one-cycle, active-low frame sync pulse. A frame normally lasts `FRAME_LEN` master-clock periods. A request can change the length of one frame, which nudges the timing of the following sample instant. A request can also add a secondary sync pulse halfway through a frame, so that a second control word can be received.

Requests come from two places. One is a pair of hardware request pins. The other is the two low control bits of the most recently completed 16-bit primary word. The serial shifter delivers those bits together with a one-cycle strobe. A signed adjustment value sets how far the frame boundary moves and in which direction. Only request patterns in which exactly one source asks for something are honoured. Every other pattern is treated as a plain transfer.

Top module: `fsync_phase_gen`

## Requirements
- R1: While `rst` is high, `fs_n` and `fs2_n` are high. The first `fs_n` pulse falls in the `FRAME_LEN`-th cycle after the first clock edge with `rst` low.
- R2: `fs_n` is low for exactly one cycle per frame. With no request pending, consecutive `fs_n` pulses are `FRAME_LEN` cycles apart.
- R3: A request code is formed as {ctl[1], ctl[0], pin[1], pin[0]}, where ctl is the latched `ctl_bits` and pin is `req_pin`. Codes 0001 and 0100 mean "later". Codes 0010 and 1000 mean "earlier". Codes 0011 and 1100 mean "secondary".
- R4: A "later" request makes the frame that begins at the sampling edge last `FRAME_LEN + adj_val` cycles.
- R5: An "earlier" request makes that frame last `FRAME_LEN - adj_val` cycles.
- R6: `adj_val` is two's complement. A negative value reverses the direction of the shift: a "later" request then shortens the frame, and an "earlier" request lengthens it.
- R7: An adjusted frame is never shorter than 4 cycles. A shorter result is clamped to 4.
- R8: Every code not listed in R3 (including 0000) leaves the frame at `FRAME_LEN` and produces no secondary pulse.
- R9: A "secondary" request keeps the frame at `FRAME_LEN`. It drives `fs2_n` low for one cycle exactly `FRAME_LEN/2` cycles after that frame's `fs_n` pulse.
- R10: An adjustment applies to one frame only; the next frame returns to `FRAME_LEN`. Latched control bits are consumed at the frame start that uses them.
- R11: `req_pin` and `adj_val` are sampled only on the clock edge that starts a frame. Control bits strobed during a frame take effect at the next frame start. Changes made later in the frame do not alter the frame already started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| adj_val | input | ADJ_W | Signed frame shift, in master-clock periods |
| req_pin | input | 2 | Hardware request pins {pin1, pin0} |
| ctl_bits | input | 2 | Control bits [1:0] of the completed primary word |
| ctl_strobe | input | 1 | One-cycle pulse at the end of a primary word |
| fs_n | output | 1 | Active-low primary frame sync, one cycle wide |
| fs2_n | output | 1 | Active-low secondary frame sync, one cycle wide |

## Verification
A corrupted frame counter or stored length shows at the ports within one frame. The next `fs_n` pulse arrives at the wrong cycle, and a cycle-by-cycle reference comparison flags that cycle. A stale latched request, or a wrong decode of one code, appears as a wrong gap in the frame that follows the sampling edge. It is caught no later than that frame's closing sync. A bad secondary flag appears as an `fs2_n` pulse that is misplaced, missing or spurious, visible `FRAME_LEN/2` cycles into the affected frame.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_LATER = 2'd1,
    REQ_EARLY = 2'd2,
    REQ_SEC   = 2'd3
  } req_e;

  localparam int MIN_FRAME = 4;
endpackage

// File: rtl/fsg_req_decode.sv
module fsg_req_decode
  import fsync_pkg::*;
(
  input  logic [1:0] ctl,
  input  logic [1:0] pin,
  output req_e       req
);
  logic [3:0] code;

  always_comb begin
    code = {ctl, pin};
    unique case (code)
      4'b0001, 4'b0100: req = REQ_LATER;
      4'b0010, 4'b1000: req = REQ_EARLY;
      4'b0011, 4'b1100: req = REQ_SEC;
      default:          req = REQ_NONE;
    endcase
  end
endmodule

// File: rtl/fsg_len_calc.sv
module fsg_len_calc
  import fsync_pkg::*;
#(
  parameter int FRAME_LEN = 64,
  parameter int ADJ_W     = 8,
  parameter int CW        = 8
) (
  input  req_e             req,
  input  logic [ADJ_W-1:0] adj,
  output logic [CW-1:0]    len
);
  localparam int SW = CW + 2;

  logic signed [SW-1:0] base_s;
  logic signed [SW-1:0] adj_s;
  logic signed [SW-1:0] sum_s;

  always_comb begin
    base_s = $signed(SW'(FRAME_LEN));
    adj_s  = $signed({{(SW-ADJ_W){adj[ADJ_W-1]}}, adj});
    case (req)
      REQ_LATER: sum_s = base_s + adj_s;
      REQ_EARLY: sum_s = base_s - adj_s;
      default:   sum_s = base_s;
    endcase
    if (sum_s < $signed(SW'(MIN_FRAME)))
      sum_s = $signed(SW'(MIN_FRAME));
    len = sum_s[CW-1:0];
  end
endmodule

// File: rtl/fsg_ctl_latch.sv
module fsg_ctl_latch (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe,
  input  logic [1:0] bits_in,
  input  logic       consume,
  output logic [1:0] ctl_q
);
  always_ff @(posedge clk) begin
    if (rst)
      ctl_q <= 2'b00;
    else if (strobe)
      ctl_q <= bits_in;
    else if (consume)
      ctl_q <= 2'b00;
  end
endmodule

// File: rtl/fsg_frame_timer.sv
module fsg_frame_timer
  import fsync_pkg::*;
#(
  parameter int FRAME_LEN = 64,
  parameter int CW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] next_len,
  input  req_e          req,
  output logic          wrap,
  output logic          fs_n,
  output logic          fs2_n
);
  localparam int HALF = FRAME_LEN / 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] cur_len;
  logic          sec_q;
  logic          mid_hit;

  assign wrap    = (cnt == cur_len - CW'(1));
  assign mid_hit = sec_q && !wrap && ((cnt + CW'(1)) == CW'(HALF));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      cur_len <= CW'(FRAME_LEN);
      sec_q   <= 1'b0;
      fs_n    <= 1'b1;
      fs2_n   <= 1'b1;
    end else begin
      fs_n  <= ~wrap;
      fs2_n <= ~mid_hit;
      if (wrap) begin
        cnt     <= '0;
        cur_len <= next_len;
        sec_q   <= (req == REQ_SEC);
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/fsync_phase_gen.sv
module fsync_phase_gen
  import fsync_pkg::*;
#(
  parameter int FRAME_LEN = 64,
  parameter int ADJ_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ADJ_W-1:0] adj_val,
  input  logic [1:0]       req_pin,
  input  logic [1:0]       ctl_bits,
  input  logic             ctl_strobe,
  output logic             fs_n,
  output logic             fs2_n
);
  localparam int CW = $clog2(FRAME_LEN + (2 ** (ADJ_W - 1)) + 1);

  logic [1:0]    ctl_q;
  logic          wrap;
  req_e          req;
  logic [CW-1:0] next_len;

  fsg_ctl_latch u_ctl (
    .clk     (clk),
    .rst     (rst),
    .strobe  (ctl_strobe),
    .bits_in (ctl_bits),
    .consume (wrap),
    .ctl_q   (ctl_q)
  );

  fsg_req_decode u_dec (
    .ctl (ctl_q),
    .pin (req_pin),
    .req (req)
  );

  fsg_len_calc #(
    .FRAME_LEN (FRAME_LEN),
    .ADJ_W     (ADJ_W),
    .CW        (CW)
  ) u_len (
    .req (req),
    .adj (adj_val),
    .len (next_len)
  );

  fsg_frame_timer #(
    .FRAME_LEN (FRAME_LEN),
    .CW        (CW)
  ) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .next_len (next_len),
    .req      (req),
    .wrap     (wrap),
    .fs_n     (fs_n),
    .fs2_n    (fs2_n)
  );
endmodule

// File: rtl/fsync_phase_gen_chk.sv
module fsync_phase_gen_chk
  import fsync_pkg::*;
#(
  parameter int FRAME_LEN = 64,
  parameter int ADJ_W     = 8
) (
  input logic clk,
  input logic rst,
  input logic fs_n,
  input logic fs2_n
);
  localparam int HALF = FRAME_LEN / 2;
  localparam int MAXL = FRAME_LEN + (2 ** (ADJ_W - 1));

  logic [15:0] since;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (!fs_n) begin
      since <= 16'd1;
      seen  <= 1'b1;
    end else if (since != 16'hFFFF) begin
      since <= since + 16'd1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (fs_n && fs2_n));

  p_fs_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    !fs_n |=> fs_n);

  p_gap_bounds_r7: assert property (@(posedge clk) disable iff (rst)
    (!fs_n && seen) |-> (since >= 16'(MIN_FRAME) && since <= 16'(MAXL)));

  p_fs2_mid_r9: assert property (@(posedge clk) disable iff (rst)
    !fs2_n |-> (seen && since == 16'(HALF)));

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
    fs_n || fs2_n);
endmodule

bind fsync_phase_gen fsync_phase_gen_chk #(
  .FRAME_LEN (FRAME_LEN),
  .ADJ_W     (ADJ_W)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .fs_n  (fs_n),
  .fs2_n (fs2_n)
);

// File: tb/sim_fsync_phase_gen.sv
`timescale 1ns/1ps
module sim_fsync_phase_gen;
  localparam int N    = 24;
  localparam int HALF = N / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] adj_val = 8'd0;
  logic [1:0] req_pin = 2'b00;
  logic [1:0] ctl_bits = 2'b00;
  logic       ctl_strobe = 1'b0;
  logic       fs_n, fs2_n;

  int    tests = 0;
  int    fails = 0;
  int    cyc = 0;
  int    fs2_seen = 0;
  string cur_tag = "R2";

  always #2.5 clk = ~clk;

  fsync_phase_gen #(.FRAME_LEN(N), .ADJ_W(8)) u0 (
    .clk(clk), .rst(rst), .adj_val(adj_val), .req_pin(req_pin),
    .ctl_bits(ctl_bits), .ctl_strobe(ctl_strobe), .fs_n(fs_n), .fs2_n(fs2_n)
  );

  // Behavioural reference: frame-oriented, counts cycles since the last frame start
  int   m_since = 0, m_len = N, m_code;
  bit   m_sec = 0;
  logic [1:0] m_ctl = 2'b00;
  logic exp_fs = 1'b1, exp_fs2 = 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_since = 0; m_len = N; m_sec = 0; m_ctl = 2'b00;
      exp_fs = 1'b1; exp_fs2 = 1'b1;
    end else begin
      m_since++;
      if (m_since == m_len) begin
        m_since = 0;
        m_code = {m_ctl, req_pin};
        m_sec = 0;
        m_len = N;
        if (m_code == 1 || m_code == 4)       m_len = N + $signed(adj_val);
        else if (m_code == 2 || m_code == 8)  m_len = N - $signed(adj_val);
        else if (m_code == 3 || m_code == 12) m_sec = 1;
        if (m_len < 4) m_len = 4;
        m_ctl = ctl_strobe ? ctl_bits : 2'b00;
        exp_fs = 1'b0;
      end else begin
        if (ctl_strobe) m_ctl = ctl_bits;
        exp_fs = 1'b1;
      end
      exp_fs2 = !(m_sec && m_since == HALF);
    end
  end

  always @(negedge clk) begin
    tests++;
    if (fs_n !== exp_fs || fs2_n !== exp_fs2) begin
      fails++;
      $display("FAIL %s cycle %0d: fs_n=%b fs2_n=%b expected %b %b",
               cur_tag, cyc, fs_n, fs2_n, exp_fs, exp_fs2);
    end
    if (fs2_n === 1'b0) fs2_seen++;
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_fs(output int t);
    do @(negedge clk); while (fs_n !== 1'b0);
    t = cyc;
  endtask

  // Frame k starts; request is set; frame k+1 starts with it sampled; measure k+1 and k+2
  task automatic pin_case(input logic [1:0] pins, input logic [7:0] adj,
                          input int exp, input string tag);
    int t0, t1, t2, t3;
    cur_tag = tag;
    wait_fs(t0);
    req_pin = pins; adj_val = adj;
    wait_fs(t1);
    req_pin = 2'b00;
    wait_fs(t2);
    check(tag, t2 - t1, exp);
    wait_fs(t3);
    check("R10 return to nominal", t3 - t2, N);
  endtask

  task automatic ctl_case(input logic [1:0] bits, input logic [7:0] adj,
                          input int exp, input string tag);
    int t0, t1, t2, t3;
    cur_tag = tag;
    wait_fs(t0);
    adj_val = adj;
    @(negedge clk); ctl_bits = bits; ctl_strobe = 1'b1;
    @(negedge clk); ctl_strobe = 1'b0; ctl_bits = 2'b00;
    wait_fs(t1);
    wait_fs(t2);
    check(tag, t2 - t1, exp);
    wait_fs(t3);
    check("R10 control bits consumed", t3 - t2, N);
  endtask

  initial begin
    int t0, t1, t2, f0;
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    check("R1 fs_n idle in reset", fs_n, 1);
    check("R1 fs2_n idle in reset", fs2_n, 1);
    rst = 1'b0;
    t0 = cyc;
    wait_fs(t1);
    check("R1 first sync delay", t1 - t0, N);
    cur_tag = "R2";
    wait_fs(t2);
    check("R2 nominal frame", t2 - t1, N);

    pin_case(2'b01, 8'sd5,  N + 5,  "R3 R4 pin later");
    pin_case(2'b10, 8'sd5,  N - 5,  "R3 R5 pin earlier");
    ctl_case(2'b01, 8'sd3,  N + 3,  "R3 R4 ctl later");
    ctl_case(2'b10, -8'sd4, N + 4,  "R6 ctl earlier negative");
    pin_case(2'b01, -8'sd7, N - 7,  "R6 pin later negative");
    pin_case(2'b01, -8'sd30, 4,     "R7 clamp");

    // R8: conflicting sources are ignored
    f0 = fs2_seen;
    cur_tag = "R8";
    wait_fs(t0);
    adj_val = 8'sd6; req_pin = 2'b11;
    @(negedge clk); ctl_bits = 2'b01; ctl_strobe = 1'b1;
    @(negedge clk); ctl_strobe = 1'b0;
    wait_fs(t1);
    req_pin = 2'b00;
    wait_fs(t2);
    check("R8 ignored code length", t2 - t1, N);
    check("R8 no secondary sync", fs2_seen - f0, 0);

    // R9: secondary via pins
    cur_tag = "R9";
    wait_fs(t0);
    req_pin = 2'b11;
    wait_fs(t1);
    req_pin = 2'b00;
    f0 = fs2_seen;
    do @(negedge clk); while (fs2_n !== 1'b0);
    check("R9 pin secondary offset", cyc - t1, HALF);
    wait_fs(t2);
    check("R9 secondary frame length", t2 - t1, N);
    check("R9 single secondary pulse", fs2_seen - f0, 1);

    // R9: secondary via control bits
    wait_fs(t0);
    @(negedge clk); ctl_bits = 2'b11; ctl_strobe = 1'b1;
    @(negedge clk); ctl_strobe = 1'b0;
    wait_fs(t1);
    do @(negedge clk); while (fs2_n !== 1'b0);
    check("R9 ctl secondary offset", cyc - t1, HALF);

    // R11: adj_val change after the sampling edge has no effect
    cur_tag = "R11";
    wait_fs(t0);
    adj_val = 8'sd5; req_pin = 2'b01;
    wait_fs(t1);
    req_pin = 2'b00; adj_val = 8'sd9;
    wait_fs(t2);
    check("R11 adj sampled at frame start", t2 - t1, N + 5);

    // R11: pins raised mid-frame and dropped before the boundary are not seen
    wait_fs(t0);
    repeat (4) @(negedge clk);
    req_pin = 2'b10;
    repeat (4) @(negedge clk);
    req_pin = 2'b00;
    wait_fs(t1);
    wait_fs(t2);
    check("R11 pins between boundaries ignored", t2 - t1, N);

    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog expired at cycle %0d (expected completion)", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule